// File: doc/BRIEF.md
# Dual-Source Bus Ready Synchronizer

This block merges ready requests from several bus sources into one ready signal for a processor. Each source raises an active-high "transfer complete" line, which counts only while that source's active-low address enable is low. The qualified requests are ORed and sampled on the processor clock. The result drives a registered ready output that the processor samples to end a wait state.

A run-time select chooses how much sampling history the ready output needs. In the shallow setting, one sample of the qualified request is enough. In the deep setting, the request must be seen on consecutive edges before ready rises, which guards against a slow or asynchronous source. In both settings ready falls on the first edge that samples the request low, so the processor never sees ready held past its hold window. In a single-bus system, all enables are tied low.

Top module: `bus_ready_sync`

## Requirements
- R1: Source i takes part in the request only while `aen_ni[i]` is 0. A source whose enable is 1 never causes `ready_o` to be 1, whatever its `rdy_i[i]` level.
- R2: The qualified request is 1 when any source has `rdy_i[i]`=1 and `aen_ni[i]`=0. With all enables at 0, every source qualifies.
- R3: When `single_stage_i`=1 at rising edge n, `ready_o` after edge n equals the qualified request sampled at edge n.
- R4: When `single_stage_i`=0 at rising edge n, `ready_o` after edge n is 1 only if the qualified request was 1 at edge n and at each of the previous DEEP_STAGES-1 edges. Any edge that fell during reset counts as 0. With the default DEEP_STAGES=2, ready rises two edges after the request rises.
- R5: If the qualified request is sampled 0 at edge n, `ready_o` is 0 after edge n in either mode.
- R6: `single_stage_i` is sampled at each rising edge and governs the output from that edge on. `ready_o` changes only at rising edges of `clk_i`.
- R7: While `rst_ni` is 0, `ready_o` is 0 and the history is cleared. After release, the deep mode again needs fresh samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock, rising-edge sampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rdy_i | input | N_SRC | Per-source transfer-complete, active high |
| aen_ni | input | N_SRC | Per-source address enable, active low |
| single_stage_i | input | 1 | 1: one-sample mode, 0: deep (multi-sample) mode |
| ready_o | output | 1 | Registered ready to the processor |

## Verification
The bench goes after requests gated by a high enable; a design with inverted or swapped enables would raise ready for the wrong source. In deep mode it drives one-cycle request pulses and the first cycle after reset release, where a design that skipped the history check or kept history across reset would assert ready early. It drops the request while ready is high to catch a design that lets ready linger for a second edge. It toggles the mode select every cycle to expose a design that applies the select one edge late.

// File: rtl/bus_ready_pkg.sv
package bus_ready_pkg;
  typedef enum logic {
    DEPTH_DEEP    = 1'b0,
    DEPTH_SHALLOW = 1'b1
  } depth_e;
endpackage

// File: rtl/ready_qualify.sv
module ready_qualify #(
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0] rdy_i,
  input  logic [N_SRC-1:0] aen_ni,
  output logic             req_o
);
  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign gated[i] = rdy_i[i] & ~aen_ni[i];
  end

  assign req_o = |gated;
endmodule

// File: rtl/ready_history.sv
// hist_o[k] is high when the request was high on the last k+1 edges.
module ready_history #(
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic [DEPTH-1:0] hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_o[0] <= 1'b0;
    else         hist_o[0] <= req_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_o[k] <= 1'b0;
      else         hist_o[k] <= hist_o[k-1] & req_i;
    end
  end
endmodule

// File: rtl/ready_out_reg.sv
module ready_out_reg
  import bus_ready_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic deep_ok_i,
  input  logic single_stage_i,
  output logic ready_o
);
  depth_e mode;
  logic   ready_d;

  assign mode = depth_e'(single_stage_i);

  always_comb begin
    unique case (mode)
      DEPTH_SHALLOW: ready_d = req_i;
      DEPTH_DEEP:    ready_d = req_i & deep_ok_i;
      default:       ready_d = 1'b0;
    endcase
  end

  // single flop on the output: no path from the select to ready_o between edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_o <= 1'b0;
    else         ready_o <= ready_d;
  end
endmodule

// File: rtl/bus_ready_sync.sv
module bus_ready_sync #(
  parameter int N_SRC       = 2,
  parameter int DEEP_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] rdy_i,
  input  logic [N_SRC-1:0] aen_ni,
  input  logic             single_stage_i,
  output logic             ready_o
);
  localparam int HistDepth = (DEEP_STAGES > 1) ? DEEP_STAGES - 1 : 1;

  logic                 req;
  logic [HistDepth-1:0] hist;
  logic                 deep_ok;

  ready_qualify #(.N_SRC(N_SRC)) i_qualify (
    .rdy_i  (rdy_i),
    .aen_ni (aen_ni),
    .req_o  (req)
  );

  ready_history #(.DEPTH(HistDepth)) i_history (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .hist_o (hist)
  );

  if (DEEP_STAGES > 1) begin : g_deep
    assign deep_ok = hist[HistDepth-1];
  end else begin : g_flat
    assign deep_ok = 1'b1;
  end

  ready_out_reg i_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req),
    .deep_ok_i      (deep_ok),
    .single_stage_i (single_stage_i),
    .ready_o        (ready_o)
  );
endmodule

// File: rtl/bus_ready_sync_chk.sv
module bus_ready_sync_chk #(
  parameter int N_SRC = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] rdy_i,
  input logic [N_SRC-1:0] aen_ni,
  input logic             single_stage_i,
  input logic             ready_o
);
  logic req_seen;
  assign req_seen = |(rdy_i & ~aen_ni);

  // R3
  a_r3_shallow_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_stage_i |=> (ready_o == $past(req_seen)));

  // R5 and R1: an unqualified request never leaves ready high
  a_r5_fast_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_seen |=> !ready_o);

  // R4
  a_r4_deep_needs_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !$past(single_stage_i)) |-> ($past(req_seen, 1) && $past(req_seen, 2)));

  // R7
  a_r7_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> !ready_o);
endmodule

bind bus_ready_sync bus_ready_sync_chk #(.N_SRC(N_SRC)) i_chk (.*);

// File: tb/test_bus_ready_sync.sv
`timescale 1ns/1ps
module test_bus_ready_sync;
  localparam int NS = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] rdy_i = '0;
  logic [NS-1:0] aen_ni = '1;
  logic          single_stage_i = 1'b1;
  logic          ready_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  bit    exp_ready = 0;
  bit    hist[$];
  string phase = "R7";

  always #4 clk_i = ~clk_i;

  bus_ready_sync #(.N_SRC(NS), .DEEP_STAGES(2)) i_bus_ready_sync (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rdy_i          (rdy_i),
    .aen_ni         (aen_ni),
    .single_stage_i (single_stage_i),
    .ready_o        (ready_o)
  );

  // reference: keep the last two qualified samples since reset
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist.delete();
      exp_ready = 0;
    end else begin
      bit q;
      int ones;
      q = 0;
      for (int i = 0; i < NS; i++) if (rdy_i[i] && !aen_ni[i]) q = 1;
      hist.push_front(q);
      if (hist.size() > 2) hist = hist[0:1];
      ones = 0;
      foreach (hist[k]) if (hist[k]) ones++;
      if (single_stage_i) exp_ready = q;
      else exp_ready = (hist.size() == 2) && (ones == 2);
    end
  end

  task automatic check();
    n_tests++;
    if (ready_o !== exp_ready) begin
      n_fail++;
      $display("FAIL %s t=%0t ready_o=%b expected=%b", phase, $time, ready_o, exp_ready);
    end
  endtask

  // sample at negedge, then drive next inputs
  task automatic step(input logic [NS-1:0] r, input logic [NS-1:0] a, input logic s);
    @(negedge clk_i);
    check();
    rdy_i = r; aen_ni = a; single_stage_i = s;
  endtask

  initial begin
    // R7: reset with everything qualified
    rdy_i = '1; aen_ni = '0;
    repeat (3) step('1, '0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R7/R4: right after release, deep mode must wait for two samples
    phase = "R7";
    repeat (3) step('1, '0, 1'b0);
    // R1: enables high gate off the requests
    phase = "R1";
    step('1, '1, 1'b1); step(2'b01, 2'b01, 1'b1); step(2'b10, 2'b10, 1'b1);
    step(2'b01, 2'b10, 1'b1); step(2'b10, 2'b01, 1'b0); step(2'b10, 2'b01, 1'b0);
    step('0, '0, 1'b1);
    // R2: each source alone and both
    phase = "R2";
    step(2'b01, 2'b00, 1'b1); step(2'b10, 2'b00, 1'b1); step(2'b11, 2'b00, 1'b1);
    step(2'b10, 2'b01, 1'b1); step(2'b01, 2'b10, 1'b1); step('0, '0, 1'b1);
    // R3: shallow mode stream
    phase = "R3";
    for (int i = 0; i < 12; i++) step(NS'(i % 3 == 0 ? 1 : 0), '0, 1'b1);
    // R4: deep mode with single-cycle pulses and long holds
    phase = "R4";
    step(2'b01, '0, 1'b0); step('0, '0, 1'b0); step(2'b01, '0, 1'b0);
    step(2'b01, '0, 1'b0); step(2'b01, '0, 1'b0); step(2'b01, '0, 1'b0);
    // R5: drop while ready is high, both modes
    phase = "R5";
    step('0, '0, 1'b0); step(2'b10, '0, 1'b0); step(2'b10, '0, 1'b0);
    step(2'b10, '0, 1'b1); step('0, '0, 1'b1); step('0, '0, 1'b1);
    // R6: toggle mode every cycle with random requests
    phase = "R6";
    for (int i = 0; i < 200; i++)
      step(NS'($urandom_range(3)), NS'($urandom_range(3) & 1), 1'(i % 2));
    // R7: mid-run reset while ready is high
    phase = "R7";
    repeat (3) step('1, '0, 1'b1);
    @(negedge clk_i); rst_ni = 1'b0;
    #1; n_tests++;
    if (ready_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 async clear ready_o=%b expected=0", ready_o);
    end
    repeat (2) step('1, '0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (4) step('1, '0, 1'b0);
    step('0, '0, 1'b0);
    @(negedge clk_i); check();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule